// File: doc/BRIEF.md
# Register Pending-Writer Rename Table

This block keeps, for every architectural floating-point register, the stored value and a pending-writer tag. The tag names the reservation station that will produce the register's next value, and zero means nothing is pending. When an instruction issues, the block looks up its two source registers. A source with nothing pending hands out its stored value. A source still waiting hands out the tag of its producer instead. In the same cycle, the issuing station's tag is written into the destination register's entry, so any later reader waits on that station.

The block also watches the result broadcast bus, which carries a station tag and 64 bits of data. A register takes the broadcast data only while its pending tag still equals the broadcast tag, and its tag is cleared to zero on that same edge. A result from a writer that a younger issue has since replaced is never stored, so an old write cannot overwrite a newer rename. A source lookup made while its producer is broadcasting gets the broadcast data straight away.

The issue side is a valid/ready stream. An issue is accepted on a clock edge where `iss_valid` and `iss_ready` are both high. `iss_ready` is low during reset and high at all other times, so the table never applies back-pressure in normal operation. The source lookup outputs are combinational and are valid whenever `iss_src_a` and `iss_src_b` are driven, whether or not an issue is presented. The broadcast bus has no ready signal and cannot be stalled.

Top module: `rrs_rename_table`

## Requirements
- R1: During reset `iss_ready` is low. After reset every register reads value 0 with tag 0, and `iss_ready` is high from the first edge after reset is released.
- R2: A source register whose pending tag is 0 returns its stored value, with 0 on the tag output.
- R3: A source register whose pending tag is nonzero, and which is not being broadcast in the current cycle, returns that tag with 0 on the value output.
- R4: An accepted issue with `iss_dst_en` high sets the destination's pending tag to `iss_tag`, and a later issue to the same register replaces the earlier tag. An issue with `iss_dst_en` low, or with `iss_valid` low, changes no entry.
- R5: A broadcast with `bc_valid` high and a nonzero `bc_tag` stores `bc_data` and clears the tag on the next edge, in every register whose pending tag equals `bc_tag`. All such registers update on the same edge.
- R6: A broadcast whose tag does not equal a register's pending tag leaves that register's value and tag unchanged. This covers the result of a writer that has been superseded.
- R7: If a register is renamed on the same edge that a broadcast of its old tag arrives, the register takes the new tag and keeps its old value.
- R8: A source whose pending tag equals `bc_tag` while `bc_valid` is high returns `bc_data` with tag 0 in that same cycle.
- R9: A broadcast with `bc_tag` equal to 0 changes no register.
- R10: The sources of an issue see the table as it was before that issue's edge, including when a source is also the destination.
- R11: `iss_tag` is nonzero whenever an issue is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An issue is presented |
| iss_ready | output | 1 | The table accepts issues |
| iss_src_a | input | REG_W | First source register index |
| iss_src_b | input | REG_W | Second source register index |
| iss_dst_en | input | 1 | The issuing instruction writes a register |
| iss_dst | input | REG_W | Destination register index |
| iss_tag | input | TAG_W | Tag of the station taking the issue (nonzero) |
| bc_valid | input | 1 | A result is on the broadcast bus |
| bc_tag | input | TAG_W | Tag of the broadcasting station |
| bc_data | input | DATA_W | Broadcast result data |
| opa_val | output | DATA_W | First source value, 0 while waiting |
| opa_tag | output | TAG_W | First source producer tag, 0 when the value is valid |
| opb_val | output | DATA_W | Second source value, 0 while waiting |
| opb_tag | output | TAG_W | Second source producer tag, 0 when the value is valid |

## Verification
The hardest case to reach is a stale result. This is a broadcast from a station that issued to a register but was then replaced by a younger issue, possibly on the very edge the broadcast arrives. The stimulus first renames one register twice and broadcasts the older tag. It then sets up a rename and a broadcast of the outgoing tag on the same edge. Around these cases, a sweep renames each register with every nonzero tag and broadcasts that tag, and a bench-side table checks all registers after each step.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  // where a source lookup gets its answer from
  typedef enum logic [1:0] {
    SRC_REG    = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_WAIT   = 2'd2
  } src_kind_e;

endpackage

// File: rtl/rrs_entry.sv
module rrs_entry #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rename_en,
  input  logic [TAG_W-1:0]  new_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic [TAG_W-1:0]  qi_o,
  output logic [DATA_W-1:0] val_o
);

  logic [TAG_W-1:0]  qi_q;
  logic [DATA_W-1:0] val_q;
  logic              snoop_hit;

  // a broadcast only counts when it names the writer still expected
  assign snoop_hit = bc_valid && (bc_tag != '0) && (qi_q == bc_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      qi_q  <= '0;
      val_q <= '0;
    end else if (rename_en) begin
      qi_q  <= new_tag;           // the younger writer takes precedence
    end else if (snoop_hit) begin
      val_q <= bc_data;
      qi_q  <= '0;
    end
  end

  assign qi_o  = qi_q;
  assign val_o = val_q;

  a_r5_accept_clears: assert property (@(posedge clk) disable iff (rst)
    (snoop_hit && !rename_en) |=> (qi_q == '0 && val_q == $past(bc_data)));

  a_r7_rename_wins: assert property (@(posedge clk) disable iff (rst)
    rename_en |=> (qi_q == $past(new_tag) && $stable(val_q)));

  a_r6_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
    (!rename_en && !snoop_hit) |=> ($stable(qi_q) && $stable(val_q)));

endmodule

// File: rtl/rrs_read_port.sv
module rrs_read_port
  import rrs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 64,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic [REG_W-1:0]                  sel,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]    qi_all,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]   val_all,
  input  logic                              bc_valid,
  input  logic [TAG_W-1:0]                  bc_tag,
  input  logic [DATA_W-1:0]                 bc_data,
  output logic [DATA_W-1:0]                 val_o,
  output logic [TAG_W-1:0]                  tag_o
);

  logic [TAG_W-1:0]  sel_qi;
  logic [DATA_W-1:0] sel_val;
  src_kind_e         kind;

  assign sel_qi  = qi_all[sel];
  assign sel_val = val_all[sel];

  always_comb begin
    if (sel_qi == '0)
      kind = SRC_REG;
    else if (bc_valid && bc_tag == sel_qi)
      kind = SRC_BYPASS;
    else
      kind = SRC_WAIT;
  end

  always_comb begin
    unique case (kind)
      SRC_REG:    begin val_o = sel_val; tag_o = '0;     end
      SRC_BYPASS: begin val_o = bc_data; tag_o = '0;     end
      default:    begin val_o = '0;      tag_o = sel_qi; end
    endcase
  end

endmodule

// File: rtl/rrs_rename_table.sv
module rrs_rename_table #(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 64,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [REG_W-1:0]  iss_src_a,
  input  logic [REG_W-1:0]  iss_src_b,
  input  logic              iss_dst_en,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic [DATA_W-1:0] opa_val,
  output logic [TAG_W-1:0]  opa_tag,
  output logic [DATA_W-1:0] opb_val,
  output logic [TAG_W-1:0]  opb_tag
);

  localparam int NUM_PORTS = 2;

  logic                            ready_q;
  logic                            iss_fire;
  logic [NUM_REGS-1:0]             rename_vec;
  logic [NUM_REGS-1:0][TAG_W-1:0]  qi_all;
  logic [NUM_REGS-1:0][DATA_W-1:0] val_all;
  logic [NUM_PORTS-1:0][REG_W-1:0]  port_sel;
  logic [NUM_PORTS-1:0][DATA_W-1:0] port_val;
  logic [NUM_PORTS-1:0][TAG_W-1:0]  port_tag;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign iss_ready = ready_q;
  assign iss_fire  = iss_valid && ready_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign rename_vec[r] = iss_fire && iss_dst_en && (iss_dst == REG_W'(r));

    rrs_entry #(
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
    ) i_entry (
      .clk       (clk),
      .rst       (rst),
      .rename_en (rename_vec[r]),
      .new_tag   (iss_tag),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag),
      .bc_data   (bc_data),
      .qi_o      (qi_all[r]),
      .val_o     (val_all[r])
    );
  end

  assign port_sel[0] = iss_src_a;
  assign port_sel[1] = iss_src_b;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    rrs_read_port #(
      .NUM_REGS (NUM_REGS),
      .TAG_W    (TAG_W),
      .DATA_W   (DATA_W),
      .REG_W    (REG_W)
    ) i_port (
      .sel      (port_sel[p]),
      .qi_all   (qi_all),
      .val_all  (val_all),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .val_o    (port_val[p]),
      .tag_o    (port_tag[p])
    );
  end

  assign opa_val = port_val[0];
  assign opa_tag = port_tag[0];
  assign opb_val = port_val[1];
  assign opb_tag = port_tag[1];

  a_r11_tag_nonzero: assert property (@(posedge clk) disable iff (rst)
    iss_fire |-> (iss_tag != '0));

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> iss_ready);

  a_r4_one_rename: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rename_vec));

  a_r3_wait_zero_value: assert property (@(posedge clk) disable iff (rst)
    (opa_tag != '0) |-> (opa_val == '0));

endmodule

// File: tb/test_rrs_rename_table.sv
module test_rrs_rename_table;

  localparam int CLK_PERIOD = 10;
  localparam int NR  = 8;
  localparam int RW  = 3;
  localparam int TW  = 4;
  localparam int DW  = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic          iss_valid, iss_ready, iss_dst_en;
  logic [RW-1:0] iss_src_a, iss_src_b, iss_dst;
  logic [TW-1:0] iss_tag;
  logic          bc_valid;
  logic [TW-1:0] bc_tag;
  logic [DW-1:0] bc_data;
  logic [DW-1:0] opa_val, opb_val;
  logic [TW-1:0] opa_tag, opb_tag;

  int total = 0;
  int fails = 0;

  logic [TW-1:0] mq [NR];
  logic [DW-1:0] mv [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  rrs_rename_table #(.NUM_REGS(NR), .TAG_W(TW), .DATA_W(DW)) i_rrs_rename_table (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst_en(iss_dst_en),
    .iss_dst(iss_dst), .iss_tag(iss_tag), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_data(bc_data), .opa_val(opa_val), .opa_tag(opa_tag),
    .opb_val(opb_val), .opb_tag(opb_tag)
  );

  function automatic logic [DW-1:0] pat(int r, int t);
    return {32'(r * 7 + 1), 32'(t * 131 + 5)} ^ 64'hC3A5_0F1E_9B2D_4C87;
  endfunction

  task automatic chk(string req, logic [DW-1:0] av, logic [DW-1:0] ev,
                     logic [TW-1:0] at, logic [TW-1:0] et);
    total++;
    if (av !== ev || at !== et) begin
      fails++;
      $display("FAIL %s: got val=%h tag=%0d, expected val=%h tag=%0d", req, av, at, ev, et);
    end
  endtask

  // one clock with the given stimulus; the bench table follows the requirements
  task automatic step(logic iv, logic den, int dst, int itag,
                      logic bv, int btag, logic [DW-1:0] bdata);
    @(negedge clk);
    iss_valid = iv; iss_dst_en = den; iss_dst = RW'(dst); iss_tag = TW'(itag);
    bc_valid = bv; bc_tag = TW'(btag); bc_data = bdata;
    @(posedge clk);
    for (int r = 0; r < NR; r++) begin
      if (iv && den && dst == r) mq[r] = TW'(itag);               // R4, R7
      else if (bv && btag != 0 && mq[r] == TW'(btag)) begin       // R5, R9
        mv[r] = bdata; mq[r] = '0;
      end
    end
  endtask

  // probe every register through both source ports with the bus idle
  task automatic check_all(string req);
    @(negedge clk);
    iss_valid = 1'b0; bc_valid = 1'b0;
    for (int r = 0; r < NR; r++) begin
      iss_src_a = RW'(r); iss_src_b = RW'((r + 3) % NR);
      #1;
      chk(req, opa_val, (mq[r] == 0) ? mv[r] : '0, opa_tag, mq[r]);
      chk(req, opb_val, (mq[(r+3)%NR] == 0) ? mv[(r+3)%NR] : '0,
          opb_tag, mq[(r+3)%NR]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst = 1'b1; iss_valid = 0; iss_dst_en = 0; iss_dst = 0; iss_tag = 0;
    iss_src_a = 0; iss_src_b = 0; bc_valid = 0; bc_tag = 0; bc_data = '0;
    for (int r = 0; r < NR; r++) begin mq[r] = '0; mv[r] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", {63'd0, iss_ready}, '0, '0, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {63'd0, iss_ready}, 64'd1, '0, '0);
    check_all("R1 reset state");

    // R4 / R5 sweep: every register, every nonzero tag
    for (int d = 0; d < NR; d++) begin
      for (int t = 1; t < 16; t++) begin
        step(1, 1, d, t, 0, 0, '0);
        check_all("R3 R4 rename");
        step(0, 0, 0, 1, 1, t, pat(d, t));
        check_all("R2 R5 broadcast");
      end
    end

    // R5: several registers pending on one tag update together
    for (int r = 0; r < NR; r += 2) step(1, 1, r, 6, 0, 0, '0);
    check_all("R3 shared tag");
    step(0, 0, 0, 1, 1, 6, 64'h1111_2222_3333_4444);
    check_all("R5 shared tag release");

    // R6: superseded writer's result is dropped
    step(1, 1, 1, 4, 0, 0, '0);
    step(1, 1, 1, 9, 0, 0, '0);
    step(0, 0, 0, 1, 1, 4, 64'hDEAD_0000_0000_0004);
    check_all("R6 stale result ignored");
    step(0, 0, 0, 1, 1, 9, 64'hBEEF_0000_0000_0009);
    check_all("R5 current writer accepted");

    // R7: rename and broadcast of old tag on the same edge
    step(1, 1, 2, 3, 0, 0, '0);
    step(1, 1, 2, 12, 1, 3, 64'h0BAD_0000_0000_0003);
    check_all("R7 rename beats broadcast");
    step(0, 0, 0, 1, 1, 12, 64'h600D_0000_0000_000C);
    check_all("R7 later accept");

    // R4: dst disabled and valid low change nothing
    step(1, 0, 3, 7, 0, 0, '0);
    step(0, 1, 4, 8, 0, 0, '0);
    check_all("R4 no rename");

    // R9: tag 0 broadcast ignored
    step(0, 0, 0, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    check_all("R9 zero tag broadcast");

    // R8: bypass in the broadcast cycle
    step(1, 1, 5, 10, 0, 0, '0);
    @(negedge clk);
    iss_valid = 0; iss_src_a = 3'd5; iss_src_b = 3'd6;
    bc_valid = 1; bc_tag = 4'd10; bc_data = 64'hA0A0_B1B1_C2C2_D3D3;
    #1;
    chk("R8 bypass", opa_val, 64'hA0A0_B1B1_C2C2_D3D3, opa_tag, '0);
    chk("R8 other source", opb_val, (mq[6] == 0) ? mv[6] : '0, opb_tag, mq[6]);
    @(posedge clk);
    mv[5] = 64'hA0A0_B1B1_C2C2_D3D3; mq[5] = '0;
    check_all("R8 after bypass");

    // R10: source equal to destination sees pre-issue state
    @(negedge clk);
    iss_valid = 1; iss_dst_en = 1; iss_dst = 3'd7; iss_tag = 4'd13;
    iss_src_a = 3'd7; iss_src_b = 3'd7; bc_valid = 0;
    #1;
    chk("R10 src a pre-issue", opa_val, (mq[7] == 0) ? mv[7] : '0, opa_tag, mq[7]);
    chk("R10 src b pre-issue", opb_val, (mq[7] == 0) ? mv[7] : '0, opb_tag, mq[7]);
    @(posedge clk);
    mq[7] = 4'd13;
    check_all("R10 after issue");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule